// File: doc/BRIEF.md
# Switching-Cycle Source and PWM Force Selector

This block sits behind one shared mode pin of a switching regulator. It decides where the regulator's switching-cycle tick comes from and whether the regulator may choose between pulse-width and pulse-frequency operation by itself. The pin has three meanings, and the block tells them apart:

- **Held low:** the internal oscillator paces the cycle and automatic mode choice is allowed.
- **Held high:** PWM is forced, but the internal oscillator still paces the cycle.
- **Toggling with an external clock:** PWM is forced and the cycle tick is taken from that clock, divided by 22.

The pin is asynchronous. It is synchronised to the system clock first, and its rising edges are counted. The internal oscillator is outside the block and arrives as a one-cycle pulse `osc_tick` per internal period. A clock is declared present when 4 rising edges fall inside one internal period. It is declared lost after 2 internal ticks pass without any rising edge, and timing then falls back to the internal tick. At the moment the external source is taken over, the divide-by-22 counter restarts. This means the first external-derived cycle is always a full one.

Top module: `pwm_sync_sel`

## Requirements
- R1: While `rst` is high and on the first cycle after, `cycle_tick`, `force_pwm` and `ext_sel` are all 0.
- R2: With the pin held low and no external source selected, each `osc_tick` pulse gives a `cycle_tick` pulse one clock later, and `force_pwm` is 0. The interval between ticks equals the internal period.
- R3: With the pin held high (no edges), `force_pwm` is 1 one clock after the synchronised level is high, `ext_sel` stays 0, and ticks still follow `osc_tick`.
- R4: When the 4th synchronised rising edge arrives within one internal period (counting from the last `osc_tick`), `ext_sel` goes to 1 on the next clock.
- R5: A toggling pin that gives at most 3 rising edges per internal period never sets `ext_sel`, and ticks keep following `osc_tick`.
- R6: While `ext_sel` is 1, `cycle_tick` pulses once every 22 synchronised rising edges of the pin, and `osc_tick` has no effect.
- R7: The divider restarts on the edge that sets `ext_sel`. The first external-derived tick appears exactly 22 pin periods after `ext_sel` rises, with no tick in between.
- R8: When 2 `osc_tick` pulses pass with no rising edge while `ext_sel` is 1, `ext_sel` clears on the second one. From then on, ticks follow `osc_tick` again.
- R9: `force_pwm` is 1 whenever, in the previous cycle, the synchronised pin was high, `ext_sel` was 1, or a rising edge had been seen since the last `osc_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_pin | input | 1 | Shared mode pin: low, static high, or external clock (asynchronous) |
| osc_tick | input | 1 | One-cycle pulse per internal oscillator period |
| cycle_tick | output | 1 | Registered switching-cycle tick for the regulator |
| force_pwm | output | 1 | Registered flag: 1 forces PWM, 0 allows automatic mode choice |
| ext_sel | output | 1 | Registered flag: 1 while the external clock paces the cycle |

## Verification
The pin is driven in four ways:
- **Held low:** separates automatic operation from forced PWM.
- **Held high:** separates a static level from a clock. PWM must be forced while the internal tick is kept.
- **Fast toggling (two rates):** the tick interval must be exactly 22 pin periods. Using two rates shows the divider follows the pin and not the oscillator.
- **Slow toggling (3 edges per period):** sits just under the detection threshold, so it must not be taken as a clock. A rate just over the threshold must be taken.

The clock is stopped both low and high to show that losing the clock returns control to the internal tick, with the right force level. A directed run measures the gap from take-over to the first external tick, to confirm the divider restart.

// File: rtl/pwm_sync_sel_pkg.sv
package pwm_sync_sel_pkg;
  typedef enum logic {
    SRC_INT = 1'b0,
    SRC_EXT = 1'b1
  } tick_src_e;
endpackage

// File: rtl/pss_pin_sync.sv
module pss_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b0;
    else     chain[0] <= pin;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[g] <= 1'b0;
      else     chain[g] <= chain[g-1];
    end
  end

  assign level = chain[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= level;
  end

  assign rise = level & ~prev;
endmodule

// File: rtl/pss_act_mon.sv
module pss_act_mon #(
  parameter int EDGES_MIN  = 4,
  parameter int LOSS_TICKS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rise,
  input  logic osc_tick,
  output logic present,
  output logic acquire,
  output logic busy
);
  localparam int EW = $clog2(EDGES_MIN + 1);
  localparam int IW = $clog2(LOSS_TICKS + 1);

  logic [EW-1:0] edge_cnt;
  logic [IW-1:0] idle_cnt;
  logic          drop;

  assign acquire = !present && rise && !osc_tick && (edge_cnt == EW'(EDGES_MIN - 1));
  assign drop    = present && osc_tick && !rise && (idle_cnt == IW'(LOSS_TICKS - 1));
  assign busy    = (edge_cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      edge_cnt <= '0;
      idle_cnt <= '0;
      present  <= 1'b0;
    end else begin
      if (osc_tick)
        edge_cnt <= rise ? EW'(1) : '0;
      else if (rise && edge_cnt != EW'(EDGES_MIN))
        edge_cnt <= edge_cnt + EW'(1);

      if (rise)
        idle_cnt <= '0;
      else if (osc_tick && idle_cnt != IW'(LOSS_TICKS))
        idle_cnt <= idle_cnt + IW'(1);

      if (acquire)   present <= 1'b1;
      else if (drop) present <= 1'b0;
    end
  end

  // R4: no take-over without a rising edge
  a_r4_acquire_needs_edge: assert property (@(posedge clk) disable iff (rst)
    (!present && !rise) |=> !present);
  // R8: the clock is only given up on an internal tick
  a_r8_drop_on_tick: assert property (@(posedge clk) disable iff (rst)
    (present && !osc_tick) |=> present);
  // R5: the edge count never passes its saturation value
  a_r5_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
    edge_cnt <= EW'(EDGES_MIN));
endmodule

// File: rtl/pss_ext_div.sv
module pss_ext_div #(
  parameter int DIV = 22
) (
  input  logic clk,
  input  logic rst,
  input  logic rise,
  input  logic restart,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  assign tick = rise && !restart && (cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (restart) cnt <= '0;
    else if (rise)    cnt <= (cnt == CW'(DIV - 1)) ? '0 : cnt + CW'(1);
  end

  // R6: the phase count stays inside one division cycle
  a_r6_cnt_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DIV - 1));
  // R7: take-over always restarts the division
  a_r7_restart_clears: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt == '0));
endmodule

// File: rtl/pwm_sync_sel.sv
module pwm_sync_sel
  import pwm_sync_sel_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int EDGES_MIN   = 4,
  parameter int LOSS_TICKS  = 2,
  parameter int DIV         = 22
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_pin,
  input  logic osc_tick,
  output logic cycle_tick,
  output logic force_pwm,
  output logic ext_sel
);
  logic      level;
  logic      rise;
  logic      present;
  logic      acquire;
  logic      busy;
  logic      div_tick;
  tick_src_e src;

  pss_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .pin(mode_pin), .level(level), .rise(rise)
  );

  pss_act_mon #(.EDGES_MIN(EDGES_MIN), .LOSS_TICKS(LOSS_TICKS)) i_mon (
    .clk(clk), .rst(rst), .rise(rise), .osc_tick(osc_tick),
    .present(present), .acquire(acquire), .busy(busy)
  );

  pss_ext_div #(.DIV(DIV)) i_div (
    .clk(clk), .rst(rst), .rise(rise), .restart(acquire), .tick(div_tick)
  );

  assign src     = present ? SRC_EXT : SRC_INT;
  assign ext_sel = present;

  always_ff @(posedge clk) begin
    if (rst) begin
      cycle_tick <= 1'b0;
      force_pwm  <= 1'b0;
    end else begin
      cycle_tick <= (src == SRC_EXT) ? div_tick : osc_tick;
      force_pwm  <= level | present | busy;
    end
  end

  // R9: a selected external clock always forces PWM
  a_r9_ext_forces: assert property (@(posedge clk) disable iff (rst)
    $past(ext_sel) |-> force_pwm);
  // R3: a high level on the pin forces PWM
  a_r3_level_forces: assert property (@(posedge clk) disable iff (rst)
    $past(level) |-> force_pwm);
  // R2: on internal timing every oscillator pulse becomes a tick
  a_r2_int_tick: assert property (@(posedge clk) disable iff (rst)
    (!ext_sel && osc_tick) |=> cycle_tick);
endmodule

// File: tb/test_pwm_sync_sel.sv
module test_pwm_sync_sel;
  localparam int OSC_P = 84;

  typedef struct packed {
    logic [1:0]  mode;     // 0 low, 1 high, 2 clock
    logic [7:0]  half;     // half period of clock in system cycles
    logic [1:0]  exp_frc;  // 2 = not checked
    logic        exp_sel;
    logic [11:0] exp_iv;
  } vec_t;

  localparam vec_t VECS [0:7] = '{
    '{2'd0, 8'd0,  2'd0, 1'b0, 12'd84},   // R2
    '{2'd1, 8'd0,  2'd1, 1'b0, 12'd84},   // R3
    '{2'd2, 8'd2,  2'd1, 1'b1, 12'd88},   // R4 R6
    '{2'd2, 8'd3,  2'd1, 1'b1, 12'd132},  // R6
    '{2'd0, 8'd0,  2'd0, 1'b0, 12'd84},   // R8 stop low
    '{2'd2, 8'd14, 2'd2, 1'b0, 12'd84},   // R5 three edges
    '{2'd2, 8'd10, 2'd1, 1'b1, 12'd440},  // R4 just over
    '{2'd1, 8'd0,  2'd1, 1'b0, 12'd84}    // R8 stop high
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_pin = 1'b0;
  logic osc_tick = 1'b0;
  logic cycle_tick, force_pwm, ext_sel;
  logic [1:0] pat_mode = 2'd0;
  int pat_half = 2;
  int osc_cnt = 0;
  int nvec = 0;
  int nfail = 0;

  always #10 clk = ~clk;

  pwm_sync_sel i_pwm_sync_sel (
    .clk(clk), .rst(rst), .mode_pin(mode_pin), .osc_tick(osc_tick),
    .cycle_tick(cycle_tick), .force_pwm(force_pwm), .ext_sel(ext_sel)
  );

  always @(posedge clk) begin
    if (osc_cnt == OSC_P - 1) begin
      osc_cnt  <= 0;
      osc_tick <= 1'b1;
    end else begin
      osc_cnt  <= osc_cnt + 1;
      osc_tick <= 1'b0;
    end
  end

  always begin
    if (pat_mode == 2'd2) begin
      repeat (pat_half) @(negedge clk);
      mode_pin = ~mode_pin;
    end else begin
      @(negedge clk);
      mode_pin = pat_mode[0];
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic measure(output int iv);
    int n = 0;
    do begin @(negedge clk); n++; end while (!cycle_tick && n < 2000);
    iv = 0;
    do begin @(negedge clk); iv++; end while (!cycle_tick && iv < 2000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog (run hung) actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    int iv;
    int n;
    int seen;
    repeat (5) @(negedge clk);
    check("R1 cycle_tick in reset", int'(cycle_tick), 0);
    check("R1 force_pwm in reset", int'(force_pwm), 0);
    check("R1 ext_sel in reset", int'(ext_sel), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 ext_sel after reset", int'(ext_sel), 0);

    foreach (VECS[i]) begin
      pat_half = int'(VECS[i].half);
      pat_mode = VECS[i].mode;
      repeat (5 * OSC_P) @(negedge clk);
      check($sformatf("R4/R5 vec%0d ext_sel", i), int'(ext_sel), int'(VECS[i].exp_sel));
      if (VECS[i].exp_frc != 2'd2)
        check($sformatf("R9 vec%0d force_pwm", i), int'(force_pwm), int'(VECS[i].exp_frc));
      measure(iv);
      check($sformatf("R6 vec%0d tick interval", i), iv, int'(VECS[i].exp_iv));
    end

    // R7 restart and R9 early force
    pat_mode = 2'd0;
    repeat (5 * OSC_P) @(negedge clk);
    n = 0;
    do begin @(negedge clk); n++; end while (!cycle_tick && n < 2000);
    pat_half = 2;
    pat_mode = 2'd2;
    repeat (10) @(negedge clk);
    check("R9 force before take-over", int'(force_pwm), 1);
    check("R4 not yet taken over", int'(ext_sel), 0);
    n = 0;
    while (!ext_sel && n < 200) begin @(negedge clk); n++; end
    check("R4 take-over happened", int'(ext_sel), 1);
    iv = 0;
    seen = 0;
    do begin @(negedge clk); iv++; end while (!cycle_tick && iv < 2000);
    check("R7 first external tick", iv, 88);

    // R8 loss timing: stop low, ext_sel gone within two internal periods
    pat_mode = 2'd0;
    repeat (2 * OSC_P + 8) @(negedge clk);
    check("R8 ext_sel after loss", int'(ext_sel), 0);
    measure(iv);
    check("R8 internal interval after loss", iv, OSC_P);

    // R1 mid-run reset with clock present
    pat_mode = 2'd2;
    repeat (4 * OSC_P) @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 ext_sel mid reset", int'(ext_sel), 0);
    check("R1 force_pwm mid reset", int'(force_pwm), 0);
    rst = 1'b0;

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule